// File: doc/BRIEF.md
# Quadrant Neuron Multiply-Accumulate Bank

This block forms the weighted pixel sums of four receptive-field neurons. The neurons share a single multiplier and a single adder. A sub-window of 20 by 20 pixels arrives in raster order, at most one pixel per clock. Each neuron covers one 10 by 10 quadrant of that window. No pixel carries a tag. The block works out where each pixel belongs from its position in the stream: a running row and column count selects the quadrant accumulator that receives the product, and the same count addresses a weight memory that holds one signed coefficient per pixel position.

A start pulse arms the block for a new sub-window. It also clears the counters and all accumulators. Once the last pixel of the window has been accumulated, the block raises a single-cycle done strobe and presents the four sums side by side on one result bus. The sums stay there until the next start. Weights are loaded through a plain write port, one address per write. Activation, the later network layers and the host side live elsewhere.

Top module: `quad_mac_bank`

## Requirements
- R1: After reset, `res_done` is low and `res_flat` is all zeros. Pixels presented before the first `win_start` are ignored and cause no done strobe.
- R2: `win_start` clears all four accumulators and the pixel position. A pixel presented in the same cycle as `win_start` is dropped. A product still in the pipeline when `win_start` arrives is also dropped.
- R3: The k-th accepted pixel of a window (k = 0..399) is at row k/20 and column k%20. It goes to neuron n = 2*(row>=10) + (col>=10). Neuron n's sum is on `res_flat[n*31 +: 31]`.
- R4: The weight applied to pixel k is the one stored at weight address k. A write with `wt_wr_en` high stores `wt_wr_data` at `wt_wr_addr`. Writes to addresses 400 and above change no stored weight.
- R5: Each product is the 8-bit unsigned pixel times the 16-bit two's-complement weight, formed as a 24-bit signed value and sign-extended. Each sum is 31-bit two's complement and holds the extreme case of 100 products of 255 x -32768 (-835584000) exactly.
- R6: `res_done` is high for exactly one cycle. That cycle is the second clock cycle after the edge that accepts pixel 399. The sums are final in that cycle and stay unchanged until the next `win_start`.
- R7: Cycles with `pix_valid` low neither advance the pixel position nor change any sum.
- R8: After pixel 399 has been accepted, further pixels are ignored until the next `win_start`. They change no sum and produce no done strobe.
- R9: No more than one accumulator changes in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| win_start | input | 1 | Starts a sub-window: clears sums and position, arms the block |
| pix_valid | input | 1 | Pixel qualifier |
| pix_data | input | 8 | Unsigned pixel value |
| wt_wr_en | input | 1 | Weight write enable |
| wt_wr_addr | input | 9 | Weight write address (raster pixel index) |
| wt_wr_data | input | 16 | Signed weight value |
| res_flat | output | 124 | Four 31-bit sums, neuron n at bits n*31 +: 31 |
| res_done | output | 1 | One-cycle strobe: sums are final |

## Verification
The bench builds the block with its default parameters: a 20-pixel window, 10-pixel tiles, 8-bit pixels and 16-bit weights. With these values the quadrant boundaries at row and column 10 can be reached, and so can the full 31-bit accumulator range, which the all-minimum-weight, all-white window drives to its most negative value. Random windows with random idle gaps exercise the steering against the positional rule. Directed windows place single pixels on either side of each quadrant edge. Other directed windows abort mid-stream and restart, put a pixel in the same cycle as the start pulse, write to weight addresses past the end of the memory, and send pixels after completion. These probe the dropped-pixel and ignored-input behaviour at the result bus.

// File: rtl/qmac_pkg.sv
package qmac_pkg;

  // Bits needed to sum n_terms signed values of prod_w bits each.
  function automatic int acc_width(input int n_terms, input int prod_w);
    return $clog2(n_terms) + prod_w;
  endfunction

  // Tile number of a (row, col) position when tiles are square and row-major.
  function automatic int tile_of(input int row, input int col,
                                 input int tile, input int tiles_per_side);
    return (row / tile) * tiles_per_side + (col / tile);
  endfunction

  // Signed product of an unsigned pixel and a signed weight.
  function automatic int pix_times_wgt(input int pix, input int wgt);
    return pix * wgt;
  endfunction

endpackage

// File: rtl/qmac_steer.sv
module qmac_steer
  import qmac_pkg::*;
#(
  parameter int WIN   = 20,
  parameter int TILE  = 10,
  parameter int IDX_W = 9,
  parameter int SEL_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             pix_valid,
  output logic             accept,
  output logic [IDX_W-1:0] pix_idx,
  output logic [SEL_W-1:0] nsel,
  output logic             last
);
  localparam int TPS  = WIN / TILE;
  localparam int NPIX = WIN * WIN;
  localparam int RC_W = $clog2(WIN);

  logic            armed;
  logic [RC_W-1:0] row;
  logic [RC_W-1:0] col;

  assign accept = armed & pix_valid & ~start;
  assign last   = accept && (pix_idx == IDX_W'(NPIX - 1));
  assign nsel   = SEL_W'(tile_of(int'(row), int'(col), TILE, TPS));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      armed   <= 1'b0;
      row     <= '0;
      col     <= '0;
      pix_idx <= '0;
    end else if (start) begin
      armed   <= 1'b1;
      row     <= '0;
      col     <= '0;
      pix_idx <= '0;
    end else if (accept) begin
      if (last) begin
        armed   <= 1'b0;
        row     <= '0;
        col     <= '0;
        pix_idx <= '0;
      end else begin
        pix_idx <= pix_idx + 1'b1;
        if (col == RC_W'(WIN - 1)) begin
          col <= '0;
          row <= row + 1'b1;
        end else begin
          col <= col + 1'b1;
        end
      end
    end
  end

  AST_RC_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(row) < WIN) && (int'(col) < WIN));                        // R3
  AST_IDX_TRACKS_RC: assert property (@(posedge clk) disable iff (!rst_n)
    int'(pix_idx) == int'(row) * WIN + int'(col));                  // R4
  AST_START_REWINDS: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (armed && pix_idx == '0));                            // R2
  AST_LAST_DISARMS: assert property (@(posedge clk) disable iff (!rst_n)
    (last && !start) |=> !armed);                                   // R8

endmodule

// File: rtl/qmac_wmem.sv
module qmac_wmem #(
  parameter int WGT_W  = 16,
  parameter int DEPTH  = 400,
  parameter int ADDR_W = 9
) (
  input  logic                    clk,
  input  logic                    wr_en,
  input  logic [ADDR_W-1:0]       wr_addr,
  input  logic signed [WGT_W-1:0] wr_data,
  input  logic [ADDR_W-1:0]       rd_addr,
  output logic signed [WGT_W-1:0] rd_data
);
  logic signed [WGT_W-1:0] mem [DEPTH];
  logic                    wr_in_range;

  assign wr_in_range = int'(wr_addr) < DEPTH;
  assign rd_data     = mem[rd_addr];

  always_ff @(posedge clk) begin
    if (wr_en && wr_in_range) begin
      mem[wr_addr] <= wr_data;
    end
  end

endmodule

// File: rtl/qmac_macc.sv
module qmac_macc #(
  parameter int PIX_W = 8,
  parameter int WGT_W = 16,
  parameter int NEUR  = 4,
  parameter int SEL_W = 2,
  parameter int ACC_W = 31
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    clear,
  input  logic                    in_vld,
  input  logic                    in_last,
  input  logic [SEL_W-1:0]        in_sel,
  input  logic [PIX_W-1:0]        pix,
  input  logic signed [WGT_W-1:0] wgt,
  output logic                    done,
  output logic [NEUR*ACC_W-1:0]   acc_flat
);
  localparam int PROD_W = PIX_W + WGT_W;
  localparam int EXT_W  = ACC_W - PROD_W;

  logic signed [PIX_W:0]        pix_s;
  logic signed [PROD_W:0]       prod_full;
  logic signed [PROD_W-1:0]     p_prod;
  logic                         p_vld;
  logic                         p_last;
  logic [SEL_W-1:0]             p_sel;
  logic [NEUR-1:0]              acc_we;
  logic signed [ACC_W-1:0]      prod_ext;

  assign pix_s     = $signed({1'b0, pix});
  assign prod_full = pix_s * wgt;
  assign prod_ext  = {{EXT_W{p_prod[PROD_W-1]}}, p_prod};

  // Pipeline stage between the multiplier and the shared adder.
  always_ff @(posedge clk) begin
    if (!rst_n || clear) begin
      p_vld  <= 1'b0;
      p_last <= 1'b0;
      p_sel  <= '0;
      p_prod <= '0;
    end else begin
      p_vld  <= in_vld;
      p_last <= in_vld & in_last;
      p_sel  <= in_sel;
      p_prod <= prod_full[PROD_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clear) done <= 1'b0;
    else                 done <= p_vld & p_last;
  end

  for (genvar g = 0; g < NEUR; g++) begin : g_acc
    logic signed [ACC_W-1:0] acc_q;
    assign acc_we[g] = p_vld && (p_sel == SEL_W'(g));
    always_ff @(posedge clk) begin
      if (!rst_n || clear)  acc_q <= '0;
      else if (acc_we[g])   acc_q <= acc_q + prod_ext;
    end
    assign acc_flat[g*ACC_W +: ACC_W] = acc_q;
  end

  AST_ONE_WRITER: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(acc_we));                                              // R9
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);                                                // R6
  AST_DONE_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    (in_vld && in_last && !clear) |=> (!done ##1 (done || $past(clear))));  // R6
  AST_CLEAR_FLUSHES: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (!p_vld && !done && acc_flat == '0));                 // R2
  AST_HOLD_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!p_vld && !clear) |=> $stable(acc_flat));                      // R7

endmodule

// File: rtl/quad_mac_bank.sv
module quad_mac_bank
  import qmac_pkg::*;
#(
  parameter  int PIX_W  = 8,
  parameter  int WGT_W  = 16,
  parameter  int WIN    = 20,
  parameter  int TILE   = 10,
  localparam int NPIX   = WIN * WIN,
  localparam int ADDR_W = $clog2(NPIX),
  localparam int TPS    = WIN / TILE,
  localparam int NEUR   = TPS * TPS,
  localparam int ACC_W  = acc_width(TILE * TILE, PIX_W + WGT_W)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  win_start,
  input  logic                  pix_valid,
  input  logic [PIX_W-1:0]      pix_data,
  input  logic                  wt_wr_en,
  input  logic [ADDR_W-1:0]     wt_wr_addr,
  input  logic [WGT_W-1:0]      wt_wr_data,
  output logic [NEUR*ACC_W-1:0] res_flat,
  output logic                  res_done
);
  localparam int SEL_W = (NEUR > 1) ? $clog2(NEUR) : 1;

  logic                    accept;
  logic                    last;
  logic [ADDR_W-1:0]       pix_idx;
  logic [SEL_W-1:0]        nsel;
  logic signed [WGT_W-1:0] wgt;

  qmac_steer #(.WIN(WIN), .TILE(TILE), .IDX_W(ADDR_W), .SEL_W(SEL_W)) u_steer (
    .clk(clk), .rst_n(rst_n), .start(win_start), .pix_valid(pix_valid),
    .accept(accept), .pix_idx(pix_idx), .nsel(nsel), .last(last)
  );

  qmac_wmem #(.WGT_W(WGT_W), .DEPTH(NPIX), .ADDR_W(ADDR_W)) u_wmem (
    .clk(clk), .wr_en(wt_wr_en), .wr_addr(wt_wr_addr),
    .wr_data($signed(wt_wr_data)), .rd_addr(pix_idx), .rd_data(wgt)
  );

  qmac_macc #(.PIX_W(PIX_W), .WGT_W(WGT_W), .NEUR(NEUR), .SEL_W(SEL_W),
              .ACC_W(ACC_W)) u_macc (
    .clk(clk), .rst_n(rst_n), .clear(win_start), .in_vld(accept),
    .in_last(last), .in_sel(nsel), .pix(pix_data), .wgt(wgt),
    .done(res_done), .acc_flat(res_flat)
  );

  AST_START_DROPS_PIXEL: assert property (@(posedge clk) disable iff (!rst_n)
    win_start |-> !accept);                                         // R2

endmodule

// File: tb/quad_mac_bank_tb.sv
module quad_mac_bank_tb;
  localparam int NP = 400;
  localparam int AW = 31;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         win_start = 1'b0;
  logic         pix_valid = 1'b0;
  logic [7:0]   pix_data = '0;
  logic         wt_wr_en = 1'b0;
  logic [8:0]   wt_wr_addr = '0;
  logic [15:0]  wt_wr_data = '0;
  logic [123:0] res_flat;
  logic         res_done;

  int n_chk = 0;
  int n_bad = 0;
  int done_cnt = 0;
  bit finished = 0;
  int px [NP];
  int wt [NP];

  quad_mac_bank u_dut (
    .clk(clk), .rst_n(rst_n), .win_start(win_start), .pix_valid(pix_valid),
    .pix_data(pix_data), .wt_wr_en(wt_wr_en), .wt_wr_addr(wt_wr_addr),
    .wt_wr_data(wt_wr_data), .res_flat(res_flat), .res_done(res_done)
  );

  always #5 clk = ~clk;

  always @(negedge clk) if (res_done === 1'b1) done_cnt++;

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  function automatic int quadrant(input int k);
    int r = k / 20;
    int c = k % 20;
    return ((r >= 10) ? 2 : 0) + ((c >= 10) ? 1 : 0);
  endfunction

  function automatic longint expected_sum(input int n);
    longint s = 0;
    for (int k = 0; k < NP; k++)
      if (quadrant(k) == n) s += longint'(px[k]) * longint'(wt[k]);
    return s;
  endfunction

  function automatic longint got(input int n);
    logic signed [AW-1:0] v;
    v = res_flat[n*AW +: AW];
    return longint'(v);
  endfunction

  task automatic write_weight(input int a, input int v);
    @(negedge clk);
    wt_wr_en = 1'b1; wt_wr_addr = 9'(a); wt_wr_data = 16'(v);
    @(negedge clk);
    wt_wr_en = 1'b0;
  endtask

  task automatic load_weights();
    for (int k = 0; k < NP; k++) write_weight(k, wt[k]);
  endtask

  task automatic pulse_start();
    @(negedge clk);
    win_start = 1'b1; pix_valid = 1'b0;
    @(negedge clk);
    win_start = 1'b0;
  endtask

  task automatic stream(input int n_pix, input int gap_pct);
    for (int k = 0; k < n_pix; k++) begin
      while (gap_pct > 0 && int'($urandom_range(99)) < gap_pct) begin
        @(negedge clk);
        pix_valid = 1'b0; pix_data = 8'($urandom);
      end
      @(negedge clk);
      pix_valid = 1'b1; pix_data = 8'(px[k % NP]);
    end
  endtask

  // Full window: start, 400 pixels, then check done timing and sums.
  task automatic run_window(input int gap_pct, input string tag);
    int d0;
    pulse_start();
    d0 = done_cnt;
    stream(NP, gap_pct);
    @(negedge clk);
    pix_valid = 1'b0;
    check(res_done == 1'b0, {tag, " R6 done not yet"}, res_done, 0);
    @(negedge clk);
    check(res_done == 1'b1, {tag, " R6 done strobe"}, res_done, 1);
    for (int n = 0; n < 4; n++)
      check(got(n) == expected_sum(n), {tag, " R3 R4 R5 sum"}, got(n), expected_sum(n));
    @(negedge clk);
    check(res_done == 1'b0, {tag, " R6 one-cycle strobe"}, res_done, 0);
    check(done_cnt == d0 + 1, {tag, " R6 single pulse"}, done_cnt - d0, 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    longint hold [4];
    int d0;
    void'($urandom(32'd20250601));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(res_done == 1'b0, "R1 done after reset", res_done, 0);
    check(res_flat == '0, "R1 sums after reset", longint'(res_flat[30:0]), 0);

    // R1: pixels before any start are ignored
    for (int k = 0; k < NP; k++) begin px[k] = 255; wt[k] = 1; end
    load_weights();
    d0 = done_cnt;
    stream(NP + 5, 0);
    @(negedge clk); pix_valid = 1'b0;
    repeat (3) @(negedge clk);
    check(done_cnt == d0, "R1 no done before start", done_cnt - d0, 0);
    check(res_flat == '0, "R1 sums untouched before start", got(0), 0);

    // R5: extreme window
    for (int k = 0; k < NP; k++) wt[k] = -32768;
    load_weights();
    run_window(0, "extreme");
    check(got(3) == -64'sd835584000, "R5 bound", got(3), -835584000);

    // R3: single pixels on both sides of each quadrant edge
    for (int k = 0; k < NP; k++) begin px[k] = 0; wt[k] = k + 1; end
    px[9] = 3; px[10] = 5; px[189] = 7; px[199] = 11;
    px[200] = 13; px[210] = 17; px[219] = 19; px[399] = 23;
    load_weights();
    run_window(0, "edges");

    // R4 R7: random weights and pixels with idle gaps
    for (int i = 0; i < 3; i++) begin
      for (int k = 0; k < NP; k++) begin
        px[k] = int'($urandom_range(255));
        wt[k] = int'($urandom_range(65535)) - 32768;
      end
      load_weights();
      run_window(i * 30, "random");
    end

    // R8: pixels after completion are ignored
    for (int n = 0; n < 4; n++) hold[n] = got(n);
    d0 = done_cnt;
    stream(6, 0);
    @(negedge clk); pix_valid = 1'b0;
    repeat (3) @(negedge clk);
    for (int n = 0; n < 4; n++)
      check(got(n) == hold[n], "R8 sums held after window", got(n), hold[n]);
    check(done_cnt == d0, "R8 no extra done", done_cnt - d0, 0);

    // R4: out-of-range weight writes leave stored weights intact
    write_weight(400, 16'h7FFF);
    write_weight(511, 16'h1234);
    write_weight(456, 16'h8000);
    run_window(10, "wr_oob R4");

    // R2: abort mid-window, restart with a pixel in the start cycle
    pulse_start();
    stream(50, 0);
    @(negedge clk);
    win_start = 1'b1; pix_valid = 1'b1; pix_data = 8'hFF;
    @(negedge clk);
    win_start = 1'b0; pix_valid = 1'b0;
    @(negedge clk);
    check(res_flat == '0, "R2 start clears in-flight", got(0), 0);
    d0 = done_cnt;
    stream(NP, 20);
    @(negedge clk); pix_valid = 1'b0;
    @(negedge clk);
    check(res_done == 1'b1, "R2 restart done", res_done, 1);
    for (int n = 0; n < 4; n++)
      check(got(n) == expected_sum(n), "R2 sums after restart", got(n), expected_sum(n));
    @(negedge clk);
    check(done_cnt == d0 + 1, "R2 single done after restart", done_cnt - d0, 1);

    summary();
  end

endmodule